// File: doc/BRIEF.md
# Command-Code Page Mode Controller

This block sits behind a bus target that has already decoded a command byte. It watches one-byte commands and keeps a small page mode that decides which quarter of a 1024-entry physical space an 8-bit register offset lands in. Three pages exist: the default page, the flash page, and the user flash page. The user flash page can only be reached by going through the flash page.

The same command stream also carries four action codes. These are block write, block read, reboot and emergency fault save. For each of them the block emits a single-cycle strobe for the engines that do the work. A reboot also behaves like a reset of the page mode. The physical address is formed from the current page and the offset that is presented in the same cycle.

Top module: `page_cmd_ctrl`

## Requirements
- R1: After reset, all four strobes are low, and `phys_addr` equals {2'b00, `reg_ofs`}. This is the default page.
- R2: An accepted A9h selects the flash page from any page. From the next cycle on, `phys_addr` = {2'b10, `reg_ofs`}.
- R3: An accepted AAh selects the default page from any page. From the next cycle on, `phys_addr` = {2'b00, `reg_ofs`}.
- R4: An accepted ABh while in the flash page selects the user flash page. From the next cycle on, `phys_addr` = {2'b11, `reg_ofs`}.
- R5: An ABh received in the default page or in the user flash page leaves the page unchanged.
- R6: An accepted ACh while in the user flash page returns to the flash page. In any other page, ACh leaves the page unchanged.
- R7: A5h raises `blk_wr_stb` and A6h raises `blk_rd_stb`. Each strobe rises in the cycle after the command is accepted, lasts one cycle per command, and does not change the page.
- R8: A7h raises `reboot_stb` in the cycle after acceptance and returns the page to default, whatever the page was before.
- R9: A8h raises `fault_save_stb` in the cycle after acceptance and does not change the page.
- R10: A command code outside A5h–ACh raises no strobe and does not change the page.
- R11: While `cmd_valid` is low, `cmd_code` is ignored. No strobe is raised and the page holds.
- R12: At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte is valid this cycle |
| cmd_code | input | 8 | Decoded command byte |
| reg_ofs | input | 8 | Register offset to translate |
| phys_addr | output | 10 | Page-qualified physical address |
| blk_wr_stb | output | 1 | Block write strobe |
| blk_rd_stb | output | 1 | Block read strobe |
| reboot_stb | output | 1 | Reboot strobe |
| fault_save_stb | output | 1 | Emergency fault save strobe |

## Verification
The hardest case to reach is a user-page command that should be rejected. An ABh has to arrive while the block is already in the user flash page, or an ACh has to arrive while it is in the flash page. Each of these needs a specific chain of earlier legal commands. The stimulus builds each chain explicitly: A9h then ABh then ABh, and A9h then ACh. It then shows that the rejected code had no effect by sweeping several offsets and reading `phys_addr`. A reboot issued from deep in the user flash page checks the return to default in one step.

// File: rtl/page_cmd_ctrl.sv
module page_cmd_ctrl #(
  parameter int OFS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [7:0]         cmd_code,
  input  logic [OFS_W-1:0]   reg_ofs,
  output logic [OFS_W+1:0]   phys_addr,
  output logic               blk_wr_stb,
  output logic               blk_rd_stb,
  output logic               reboot_stb,
  output logic               fault_save_stb
);

  localparam logic [7:0] C_BWR   = 8'hA5;
  localparam logic [7:0] C_BRD   = 8'hA6;
  localparam logic [7:0] C_BOOT  = 8'hA7;
  localparam logic [7:0] C_SAVE  = 8'hA8;
  localparam logic [7:0] C_FON   = 8'hA9;
  localparam logic [7:0] C_FOFF  = 8'hAA;
  localparam logic [7:0] C_UON   = 8'hAB;
  localparam logic [7:0] C_UOFF  = 8'hAC;

  localparam logic [1:0] PG_DEF  = 2'b00;
  localparam logic [1:0] PG_FL   = 2'b10;
  localparam logic [1:0] PG_USR  = 2'b11;

  logic [1:0] page_q, page_d;
  logic [3:0] stb_d, stb_q;

  always_comb begin
    page_d = page_q;
    stb_d  = '0;
    if (cmd_valid) begin
      case (cmd_code)
        C_BWR:  stb_d[0] = 1'b1;
        C_BRD:  stb_d[1] = 1'b1;
        C_BOOT: begin stb_d[2] = 1'b1; page_d = PG_DEF; end
        C_SAVE: stb_d[3] = 1'b1;
        C_FON:  page_d = PG_FL;
        C_FOFF: page_d = PG_DEF;
        C_UON:  if (page_q == PG_FL)  page_d = PG_USR;
        C_UOFF: if (page_q == PG_USR) page_d = PG_FL;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= PG_DEF;
      stb_q  <= '0;
    end else begin
      page_q <= page_d;
      stb_q  <= stb_d;
    end
  end

  assign phys_addr      = {page_q, reg_ofs};
  assign blk_wr_stb     = stb_q[0];
  assign blk_rd_stb     = stb_q[1];
  assign reboot_stb     = stb_q[2];
  assign fault_save_stb = stb_q[3];

  p_onehot_stb_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({blk_wr_stb, blk_rd_stb, reboot_stb, fault_save_stb}));

  p_user_via_flash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phys_addr[OFS_W+1:OFS_W] == PG_USR && $past(page_q) != PG_USR)
      |-> $past(page_q) == PG_FL);

  p_boot_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_stb |-> page_q == PG_DEF);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(page_q) && stb_q == 4'b0000));

  p_stb_needs_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_wr_stb || blk_rd_stb) |-> $past(cmd_valid));

  p_no_page_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q != $past(page_q)) |-> $past(cmd_valid));

endmodule

// File: tb/sim_page_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_page_cmd_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00, reg_ofs = 8'h00;
  logic [9:0] phys_addr;
  logic blk_wr_stb, blk_rd_stb, reboot_stb, fault_save_stb;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  page_cmd_ctrl u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .reg_ofs(reg_ofs), .phys_addr(phys_addr), .blk_wr_stb(blk_wr_stb), .blk_rd_stb(blk_rd_stb),
    .reboot_stb(reboot_stb), .fault_save_stb(fault_save_stb));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] stbs();
    return {fault_save_stb, reboot_stb, blk_rd_stb, blk_wr_stb};
  endfunction

  // send one command; returns strobes seen in the following cycle
  task automatic send(logic [7:0] c, output logic [3:0] s);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 8'h00;
    s = stbs();
  endtask

  task automatic page_is(string req, logic [1:0] pg);
    logic [7:0] ofs[3] = '{8'h00, 8'h5A, 8'hFF};
    foreach (ofs[i]) begin
      reg_ofs = ofs[i]; #0.5;
      chk(req, phys_addr, {pg, ofs[i]});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 strobes", stbs(), 4'b0);
    page_is("R1", 2'b00);
  endtask

  task automatic t_flash_default();
    logic [3:0] s;
    send(8'hA9, s); chk("R2 no strobe", s, 4'b0); page_is("R2", 2'b10);
    send(8'hA9, s); page_is("R2 again", 2'b10);
    send(8'hAA, s); page_is("R3 from flash", 2'b00);
  endtask

  task automatic t_user_paths();
    logic [3:0] s;
    send(8'hA9, s); send(8'hAB, s); page_is("R4", 2'b11);
    send(8'hAB, s); page_is("R5 in user", 2'b11);
    send(8'hAC, s); page_is("R6 back to flash", 2'b10);
    send(8'hAC, s); page_is("R6 ignored in flash", 2'b10);
    send(8'hAB, s); send(8'hAA, s); page_is("R3 from user", 2'b00);
    send(8'hAB, s); page_is("R5 in default", 2'b00);
    send(8'hAC, s); page_is("R6 ignored in default", 2'b00);
    send(8'hA9, s); send(8'hAB, s); send(8'hA9, s); page_is("R2 from user", 2'b10);
  endtask

  task automatic t_actions();
    logic [3:0] s;
    send(8'hA9, s); send(8'hAB, s);
    send(8'hA5, s); chk("R7 write strobe", s, 4'b0001);
    @(negedge clk); chk("R7 one cycle", stbs(), 4'b0);
    send(8'hA6, s); chk("R7 read strobe", s, 4'b0010);
    send(8'hA8, s); chk("R9 save strobe", s, 4'b1000);
    page_is("R7 R9 page kept", 2'b11);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = 8'hA5;
    @(negedge clk); chk("R7 back-to-back 1", stbs(), 4'b0001); cmd_code = 8'hA6;
    @(negedge clk); chk("R7 back-to-back 2 R12", stbs(), 4'b0010); cmd_valid = 1'b0;
    send(8'hA7, s); chk("R8 reboot strobe", s, 4'b0100);
    page_is("R8 default", 2'b00);
  endtask

  task automatic t_unknown_idle();
    logic [3:0] s;
    send(8'hA9, s);
    send(8'h00, s); chk("R10 code 00", s, 4'b0);
    send(8'hA4, s); chk("R10 code A4", s, 4'b0);
    send(8'hAD, s); chk("R10 code AD", s, 4'b0);
    page_is("R10 page kept", 2'b10);
    @(negedge clk); cmd_code = 8'hA7;
    @(negedge clk); chk("R11 no strobe", stbs(), 4'b0); cmd_code = 8'hAA;
    @(negedge clk); cmd_code = 8'h00;
    page_is("R11 page kept", 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flash_default();
    t_user_paths();
    t_actions();
    t_unknown_idle();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule